// File: doc/BRIEF.md
# Profile-Driven Waveform RAM Playback Sequencer

This block holds a 1024-word by 32-bit waveform memory and eight playback profiles. Each profile describes an address window (a low and a high address), a step-rate divider and a playback mode. While playback is enabled, a read address walks through the window of the selected profile. Each step comes after a fixed number of clock cycles set by that profile's divider. The addressed word is presented on a data output together with a two-bit destination tag, which tells the downstream synthesis datapath whether the word is a frequency, phase, amplitude or polar value.

Software first programs the profiles and the control word while playback is off. It then streams waveform words through a sequential load port into the window of the externally selected profile, and finally raises the enable. The profile is chosen by a 3-bit select input. An internal sequencer can instead chain profiles 0, 1, 2 and so on up to a target profile, either once or repeatedly.

Top module: `ramPlaySeq`

## Requirements
- R1: After reset, dataValid, curAddr, activeProfile and destOut are all 0. Every profile starts with window 0..1023, divider 1 and mode 0 (direct).
- R2: A profile write stores cfgStart, cfgEnd, cfgRate and cfgMode into profile cfgWrIdx. If cfgEnd is below cfgStart, the stored high address equals cfgStart.
- R3: Profile writes, control writes and load strobes have no effect while ramEn is high.
- R4: While loadEn stays high, each cycle writes loadData at consecutive addresses, from the low to the high address of the profile picked by extProfile. Words beyond the high address are dropped. One low cycle of loadEn returns the pointer to the low address.
- R5: On the clock edge where ramEn is first seen high, curAddr loads the low address of the profile being played. After that the address can move only on every (4 × divider)-th edge, and a divider of 0 acts as 1. While ramEn is low the address holds, and it never changes on two edges in a row.
- R6: dataValid equals ramEn delayed by two clock edges. dataOut carries the word at curAddr one edge after curAddr settles.
- R7: Mode 0 (direct) holds the low address.
- R8: Mode 1 (ramp) steps up by one per step to the high address, then holds there.
- R9: Mode 2 (pin ramp) moves up toward the high address while extProfile bit 0 is 1 and down toward the low address while it is 0. A change of select does not switch the profile being played.
- R10: Mode 3 (ping-pong) steps up to the high address, then turns and steps down to the low address, and repeats. A one-word window holds.
- R11: Mode 4 (recirculate) steps up and wraps from the high address back to the low address.
- R12: With the sequencer off, in any mode except 2, a change of extProfile makes the next step load the new profile's low address and switch activeProfile.
- R13: ctlSeq is 5 bits: bit 4 = repeat, and a nonzero value enables the sequencer. The target is bits 2:0, or bits 2:0 plus one when bit 4 is set. Playback starts at profile 0 and ramps each profile once, going to the next profile at the step after its high address. At the target's high address it either holds or, when repeat is set, restarts at profile 0. extProfile is ignored.
- R14: destOut shows the ctlDest value last written, and it does not change while ramEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ramEn | input | 1 | Playback enable; also locks the configuration |
| extProfile | input | 3 | External profile select |
| cfgWrEn | input | 1 | Profile write strobe |
| cfgWrIdx | input | 3 | Profile to write |
| cfgStart | input | 10 | Window low address |
| cfgEnd | input | 10 | Window high address |
| cfgRate | input | 16 | Step divider |
| cfgMode | input | 3 | Playback mode code |
| ctlWrEn | input | 1 | Control word write strobe |
| ctlDest | input | 2 | Destination tag: 0 freq, 1 phase, 2 amplitude, 3 polar |
| ctlSeq | input | 5 | Sequencer field |
| loadEn | input | 1 | Sequential load strobe |
| loadData | input | 32 | Word to load |
| dataOut | output | 32 | Word at the playback address |
| dataValid | output | 1 | Playback output valid |
| destOut | output | 2 | Destination tag of dataOut |
| curAddr | output | 10 | Playback address |
| activeProfile | output | 3 | Profile currently played |

## Verification
The assertions assume that ramEn stays low during reset and for the first two cycles after it, so the two-edge valid relation has a defined history. They also assume that configuration and load traffic only changes state while ramEn is low. The stimulus drives every input on the falling clock edge. It changes configuration and loads words only between playback runs, except for the deliberate writes in the ignored-write test. Every run is started from a low ramEn, and random windows are kept inside the memory so that every high address is at least the low address.

// File: rtl/ramPlayPkg.sv
package ramPlayPkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int RATE_W   = 16;
  localparam int PROF_W   = 3;
  localparam int NUM_PROF = 1 << PROF_W;
  localparam int DEST_W   = 2;
  localparam int SEQ_W    = 5;
  localparam int MODE_W   = 3;
  localparam int CNT_W    = RATE_W + 2;

  localparam logic [MODE_W-1:0] MODE_DIRECT  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_RAMP    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_PIN     = 3'd2;
  localparam logic [MODE_W-1:0] MODE_PONG    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_RECIRC  = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic              loadStart;
    logic              inc;
    logic              dec;
    logic [PROF_W-1:0] tgt;
    logic [PROF_W-1:0] cur;
  } stepCmd_t;

  // status of the profile being played
  typedef struct packed {
    logic              atStart;
    logic              atEnd;
    logic [RATE_W-1:0] rate;
    logic [MODE_W-1:0] mode;
  } playStat_t;
endpackage

// File: rtl/ramPlayData.sv
module ramPlayData
  import ramPlayPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ramEn,
  input  logic              cfgWrEn,
  input  logic [PROF_W-1:0] cfgWrIdx,
  input  logic [ADDR_W-1:0] cfgStart,
  input  logic [ADDR_W-1:0] cfgEnd,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadData,
  input  logic [PROF_W-1:0] loadProf,
  input  stepCmd_t          cmd,
  output playStat_t         stat,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [NUM_PROF-1:0][ADDR_W-1:0] profLo;
  logic [NUM_PROF-1:0][ADDR_W-1:0] profHi;
  logic [NUM_PROF-1:0][RATE_W-1:0] profRate;
  logic [NUM_PROF-1:0][MODE_W-1:0] profMode;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] ldPtr;
  logic              ldFull;
  logic              memWe;
  logic [ADDR_W-1:0] hiFixed;

  assign hiFixed = (cfgEnd < cfgStart) ? cfgStart : cfgEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PROF; p++) begin
        profLo[p]   <= '0;
        profHi[p]   <= '1;
        profRate[p] <= RATE_W'(1);
        profMode[p] <= MODE_DIRECT;
      end
    end else if (cfgWrEn && !ramEn) begin
      profLo[cfgWrIdx]   <= cfgStart;
      profHi[cfgWrIdx]   <= hiFixed;
      profRate[cfgWrIdx] <= cfgRate;
      profMode[cfgWrIdx] <= cfgMode;
    end
  end

  // sequential load pointer
  assign memWe = loadEn && !ramEn && !ldFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldPtr  <= '0;
      ldFull <= 1'b0;
    end else if (!loadEn) begin
      ldPtr  <= profLo[loadProf];
      ldFull <= 1'b0;
    end else if (memWe) begin
      ldPtr <= ldPtr + 1'b1;
      if (ldPtr == profHi[loadProf]) ldFull <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (memWe) mem[ldPtr] <= loadData;
    rdData <= mem[addr];
  end

  // playback address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addr <= '0;
    else if (cmd.loadStart) addr <= profLo[cmd.tgt];
    else if (cmd.inc) addr <= addr + 1'b1;
    else if (cmd.dec) addr <= addr - 1'b1;
  end

  always_comb begin
    stat.atStart = (addr == profLo[cmd.cur]);
    stat.atEnd   = (addr == profHi[cmd.cur]);
    stat.rate    = profRate[cmd.cur];
    stat.mode    = profMode[cmd.cur];
  end
endmodule

// File: rtl/ramPlayCtrl.sv
module ramPlayCtrl
  import ramPlayPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ramEn,
  input  logic [PROF_W-1:0] extProf,
  input  logic [SEQ_W-1:0]  seqCfg,
  input  playStat_t         stat,
  output stepCmd_t          cmd,
  output logic              running,
  output logic [PROF_W-1:0] playProf
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lim;
  logic [RATE_W-1:0] rateEff;
  logic              dirUp, nextDir;
  logic              rise, tick;
  logic              seqOn, seqRep;
  logic [PROF_W-1:0] seqTgt;

  assign seqOn  = |seqCfg;
  assign seqRep = seqCfg[SEQ_W-1];
  always_comb begin
    if (!seqRep) seqTgt = seqCfg[PROF_W-1:0];
    else if (&seqCfg[PROF_W-1:0]) seqTgt = '1;
    else seqTgt = seqCfg[PROF_W-1:0] + 1'b1;
  end

  assign rise    = ramEn && !running;
  assign rateEff = (stat.rate == '0) ? RATE_W'(1) : stat.rate;
  assign lim     = {rateEff, 2'b00};
  assign tick    = ramEn && !rise && (cnt >= lim - 1'b1);

  always_comb begin
    cmd     = '0;
    cmd.cur = playProf;
    cmd.tgt = playProf;
    nextDir = dirUp;
    if (rise) begin
      cmd.loadStart = 1'b1;
      cmd.tgt       = seqOn ? '0 : extProf;
      nextDir       = 1'b1;
    end else if (tick) begin
      if (seqOn) begin
        if (!stat.atEnd) cmd.inc = 1'b1;
        else if (playProf != seqTgt) begin
          cmd.loadStart = 1'b1;
          cmd.tgt       = playProf + 1'b1;
        end else if (seqRep) begin
          cmd.loadStart = 1'b1;
          cmd.tgt       = '0;
        end
      end else if (stat.mode != MODE_PIN && extProf != playProf) begin
        cmd.loadStart = 1'b1;
        cmd.tgt       = extProf;
        nextDir       = 1'b1;
      end else begin
        case (stat.mode)
          MODE_RAMP: cmd.inc = !stat.atEnd;
          MODE_PIN: begin
            if (extProf[0]) cmd.inc = !stat.atEnd;
            else cmd.dec = !stat.atStart;
          end
          MODE_PONG: begin
            if (dirUp) begin
              if (!stat.atEnd) cmd.inc = 1'b1;
              else if (!stat.atStart) begin
                cmd.dec = 1'b1;
                nextDir = 1'b0;
              end
            end else begin
              if (!stat.atStart) cmd.dec = 1'b1;
              else if (!stat.atEnd) begin
                cmd.inc = 1'b1;
                nextDir = 1'b1;
              end
            end
          end
          MODE_RECIRC: begin
            if (stat.atEnd) cmd.loadStart = 1'b1;
            else cmd.inc = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      cnt      <= '0;
      playProf <= '0;
      dirUp    <= 1'b1;
    end else begin
      running <= ramEn;
      if (!ramEn || rise || tick) cnt <= '0;
      else cnt <= cnt + 1'b1;
      if (cmd.loadStart) playProf <= cmd.tgt;
      dirUp <= nextDir;
    end
  end
endmodule

// File: rtl/ramPlaySeq.sv
module ramPlaySeq
  import ramPlayPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ramEn,
  input  logic [PROF_W-1:0] extProfile,
  input  logic              cfgWrEn,
  input  logic [PROF_W-1:0] cfgWrIdx,
  input  logic [ADDR_W-1:0] cfgStart,
  input  logic [ADDR_W-1:0] cfgEnd,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              ctlWrEn,
  input  logic [DEST_W-1:0] ctlDest,
  input  logic [SEQ_W-1:0]  ctlSeq,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic [DEST_W-1:0] destOut,
  output logic [ADDR_W-1:0] curAddr,
  output logic [PROF_W-1:0] activeProfile
);
  stepCmd_t         stepCmd;
  playStat_t        playStat;
  logic             running;
  logic [SEQ_W-1:0] seqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destOut   <= '0;
      seqQ      <= '0;
      dataValid <= 1'b0;
    end else begin
      if (ctlWrEn && !ramEn) begin
        destOut <= ctlDest;
        seqQ    <= ctlSeq;
      end
      dataValid <= running;
    end
  end

  ramPlayCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .ramEn(ramEn), .extProf(extProfile),
    .seqCfg(seqQ), .stat(playStat), .cmd(stepCmd), .running(running),
    .playProf(activeProfile)
  );

  ramPlayData data_i (
    .clk(clk), .rstN(rstN), .ramEn(ramEn), .cfgWrEn(cfgWrEn),
    .cfgWrIdx(cfgWrIdx), .cfgStart(cfgStart), .cfgEnd(cfgEnd),
    .cfgRate(cfgRate), .cfgMode(cfgMode), .loadEn(loadEn),
    .loadData(loadData), .loadProf(extProfile), .cmd(stepCmd),
    .stat(playStat), .addr(curAddr), .rdData(dataOut)
  );
endmodule

// File: rtl/ramPlaySeqChk.sv
module ramPlaySeqChk
  import ramPlayPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ramEn,
  input logic              dataValid,
  input logic [DEST_W-1:0] destOut,
  input logic [ADDR_W-1:0] curAddr
);
  p_valid_lag_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid == $past(ramEn, 2));

  p_idle_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ramEn |=> $stable(curAddr));

  p_single_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (curAddr != $past(curAddr)) |=> $stable(curAddr));

  p_dest_hold_r14: assert property (@(posedge clk) disable iff (!rstN)
    $past(ramEn) |-> $stable(destOut));
endmodule

bind ramPlaySeq ramPlaySeqChk chk_i (
  .clk(clk), .rstN(rstN), .ramEn(ramEn), .dataValid(dataValid),
  .destOut(destOut), .curAddr(curAddr)
);

// File: tb/ramPlaySeq_tb_top.sv
`timescale 1ns/1ps
module ramPlaySeq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ramEn = 1'b0;
  logic [2:0]  extProfile = '0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgWrIdx = '0;
  logic [9:0]  cfgStart = '0, cfgEnd = '0;
  logic [15:0] cfgRate = '0;
  logic [2:0]  cfgMode = '0;
  logic        ctlWrEn = 1'b0;
  logic [1:0]  ctlDest = '0;
  logic [4:0]  ctlSeq = '0;
  logic        loadEn = 1'b0;
  logic [31:0] loadData = '0;
  logic [31:0] dataOut;
  logic        dataValid;
  logic [1:0]  destOut;
  logic [9:0]  curAddr;
  logic [2:0]  activeProfile;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int e0 = 0;
  logic [31:0] expMem [1024];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ramPlaySeq dut_i (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int expAddr(input int mode, input int s, input int e, input int n);
    int a = s;
    bit up = 1'b1;
    for (int i = 0; i < n; i++) begin
      case (mode)
        1: if (a < e) a++;
        3: begin
          if (up) begin
            if (a < e) a++;
            else if (a > s) begin a--; up = 1'b0; end
          end else begin
            if (a > s) a--;
            else if (a < e) begin a++; up = 1'b1; end
          end
        end
        4: a = (a == e) ? s : a + 1;
        default: ;
      endcase
    end
    return a;
  endfunction

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic writeProf(input int idx, input int s, input int e, input int rate, input int mode);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrIdx = 3'(idx); cfgStart = 10'(s); cfgEnd = 10'(e);
    cfgRate = 16'(rate); cfgMode = 3'(mode);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic writeCtl(input int dest, input int seq);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlDest = 2'(dest); ctlSeq = 5'(seq);
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic loadBurst(input int prof, input int s, input int e, input int count, input bit takes);
    @(negedge clk);
    extProfile = 3'(prof); loadEn = 1'b0;
    @(negedge clk);
    for (int i = 0; i < count; i++) begin
      loadEn = 1'b1;
      loadData = $urandom;
      if (takes && i <= e - s) expMem[s + i] = loadData;
      @(negedge clk);
    end
    loadEn = 1'b0;
  endtask

  task automatic startPlay(input int prof);
    @(negedge clk);
    extProfile = 3'(prof); ramEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    e0 = cyc;
  endtask

  task automatic stopPlay();
    @(negedge clk);
    ramEn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic chkStep(input string req, input int rate, input int n, input int expA);
    waitUntil(e0 + 4 * rate * n + 1);
    chk(req, "addr", 32'(curAddr), 32'(expA));
    chk(req, "data", dataOut, expMem[expA]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seedDummy;
    int expSeqA [8];
    int expSeqP [8];
    seedDummy = $urandom(32'd4711);
    for (int i = 0; i < 1024; i++) expMem[i] = 'x;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "valid", 32'(dataValid), 0);
    chk("R1", "addr", 32'(curAddr), 0);
    chk("R1", "profile", 32'(activeProfile), 0);
    chk("R1", "dest", 32'(destOut), 0);

    // R4 full load into default profile 0 window (R1 default 0..1023)
    loadBurst(0, 0, 1023, 1024, 1'b1);
    // R1 default direct mode, divider 1
    startPlay(0);
    chkStep("R1", 1, 3, 0);
    chk("R6", "valid", 32'(dataValid), 1);
    stopPlay();

    // R14 destination tag
    writeCtl(2, 0);
    @(negedge clk);
    chk("R14", "dest", 32'(destOut), 2);

    // R8 ramp on profile 1
    writeProf(1, 10, 13, 1, 1);
    writeProf(3, 7, 20, 1, 0);
    startPlay(1);
    for (int n = 0; n < 6; n++) chkStep("R8", 1, n, expAddr(1, 10, 13, n));
    // R12 profile change restarts at next step
    @(negedge clk);
    extProfile = 3'd3;
    repeat (8) @(negedge clk);
    chk("R12", "profile", 32'(activeProfile), 3);
    chk("R12", "addr", 32'(curAddr), 7);
    // R7 direct holds
    repeat (20) @(negedge clk);
    chk("R7", "addr", 32'(curAddr), 7);
    chk("R7", "data", dataOut, expMem[7]);
    // R3 writes while enabled are ignored
    writeProf(3, 600, 610, 1, 1);
    writeCtl(1, 0);
    loadBurst(3, 7, 20, 3, 1'b0);
    chk("R3", "dest", 32'(destOut), 2);
    stopPlay();
    startPlay(3);
    chkStep("R3", 1, 2, 7);

    stopPlay();
    // R5 exact timing with divider 3, recirculate R11
    writeProf(2, 100, 102, 3, 4);
    startPlay(2);
    waitUntil(e0 + 11);
    chk("R5", "addr before step", 32'(curAddr), 100);
    waitUntil(e0 + 12);
    chk("R5", "addr at step", 32'(curAddr), 101);
    for (int n = 1; n < 8; n++) chkStep("R11", 3, n, expAddr(4, 100, 102, n));
    stopPlay();

    // R5 divider 0 acts as 1
    writeProf(2, 50, 60, 0, 1);
    startPlay(2);
    for (int n = 0; n < 4; n++) chkStep("R5", 1, n, 50 + n);
    stopPlay();

    // R10 ping-pong
    writeProf(4, 30, 33, 1, 3);
    startPlay(4);
    for (int n = 0; n < 11; n++) chkStep("R10", 1, n, expAddr(3, 30, 33, n));
    stopPlay();

    // R2 high below low is clamped
    writeProf(6, 300, 200, 1, 1);
    startPlay(6);
    chkStep("R2", 1, 3, 300);
    stopPlay();

    // R9 pin ramp, profile pinned
    writeProf(5, 40, 43, 1, 2);
    startPlay(5);
    chkStep("R9", 1, 5, 43);
    @(negedge clk);
    extProfile = 3'd4;
    repeat (30) @(negedge clk);
    chk("R9", "addr", 32'(curAddr), 40);
    chk("R9", "profile", 32'(activeProfile), 5);
    stopPlay();

    // R4 partial load: fourth word dropped, pointer restart
    writeProf(7, 900, 902, 1, 1);
    loadBurst(7, 900, 902, 4, 1'b1);
    loadBurst(7, 900, 902, 1, 1'b1);
    writeProf(7, 900, 903, 1, 1);
    startPlay(7);
    for (int n = 0; n < 4; n++) chkStep("R4", 1, n, 900 + n);
    stopPlay();

    // random windows over ramp, ping-pong, recirculate
    for (int t = 0; t < 8; t++) begin
      int s, e, r, m, k;
      s = $urandom_range(0, 1000);
      e = s + $urandom_range(0, 7);
      r = $urandom_range(1, 3);
      k = $urandom_range(0, 2);
      m = (k == 0) ? 1 : (k == 1) ? 3 : 4;
      writeProf(6, s, e, r, m);
      startPlay(6);
      for (int n = 0; n < 10; n++)
        chkStep((m == 1) ? "R8" : (m == 3) ? "R10" : "R11", r, n, expAddr(m, s, e, n));
      stopPlay();
    end

    // R13 sequencer one-shot to target 2, then repeat
    writeProf(0, 0, 1, 1, 0);
    writeProf(1, 10, 11, 1, 4);
    writeProf(2, 20, 21, 2 - 1, 3);
    writeCtl(2, 5'b00010);
    expSeqA = '{0, 1, 10, 11, 20, 21, 21, 21};
    expSeqP = '{0, 0, 1, 1, 2, 2, 2, 2};
    startPlay(5);
    for (int n = 0; n < 8; n++) begin
      chkStep("R13", 1, n, expSeqA[n]);
      chk("R13", "profile", 32'(activeProfile), 32'(expSeqP[n]));
    end
    stopPlay();
    writeCtl(2, 5'b10001);
    expSeqA = '{0, 1, 10, 11, 20, 21, 0, 1};
    expSeqP = '{0, 0, 1, 1, 2, 2, 0, 0};
    startPlay(6);
    for (int n = 0; n < 8; n++) begin
      chkStep("R13", 1, n, expSeqA[n]);
      chk("R13", "profile", 32'(activeProfile), 32'(expSeqP[n]));
    end
    stopPlay();
    chk("R6", "valid low", 32'(dataValid), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule